// File: doc/BRIEF.md
# Digital IF Quadrature Detector

This block turns a finite record of oversampled intermediate-frequency ADC samples into one complex value per receiver channel. Every channel is mixed with a single tunable numerically controlled oscillator (NCO). The products are summed over a programmable number of samples. A record of a thousand or more samples therefore collapses into a single real (I) and imaginary (Q) pair per channel. The IF sits wherever the tuning word places it. Detection quality comes from the record length: a longer record gives a narrower effective bandwidth, at about the sample rate divided by the record length.

A second mode skips the arithmetic. It stores the raw multi-channel sample words into a local buffer, so that software can read back transient or pulsed waveforms later. The record length, tuning word and mode are all latched from the control inputs when a start pulse is accepted.

Top module: `iq_detector`

## Requirements
- R1: After reset, busy_o, done_o, res_valid_o and cap_full_o are low, and all I/Q results and cap_level_o are zero.
- R2: In detect mode (mode_i=0), I = sum of x[n]*C[k] and Q = sum of x[n]*S[k] over the record. The index k is bits 31:24 of the phase, which a start sets to 0 and each counted sample advances by tune_i (mod 2^32). The table holds S[k] = round(2047*sin(2*pi*k/256)) to within 4 LSB, exact (0 or +/-2047) at multiples of 64, and C[k] = S[(k+64) mod 256].
- R3: All channels share one oscillator phase. Channel c takes its sample from samp_i[16c+15:16c] and returns its results in res_i_o/res_q_o bits [41c+40:41c]. Results are signed two's complement.
- R4: busy_o rises on the clock edge that accepts a start with a nonzero length. The last sample of a record is accepted at edge k. At edge k+1, busy_o falls, and done_o and res_valid_o are high for exactly one cycle.
- R5: Only cycles with samp_valid_i high count as samples. Idle cycles inside a record neither advance the phase nor add to the sums.
- R6: A start that arrives while busy_o is high is ignored. The record in progress finishes with its original length, mode and tuning.
- R7: A record length of zero gives done_o on the edge after the start, with busy_o staying low. In detect mode it also gives res_valid_o with zero results. In capture mode it gives cap_full_o high and cap_level_o = 0.
- R8: I/Q results hold their value from one res_valid_o pulse until the next. Samples that arrive while idle do not change them.
- R9: In capture mode (mode_i=1), each valid sample word (all channels, with channel c at bits [16c+15:16c]) is stored at consecutive addresses starting at 0. cap_rd_data_o shows the word at cap_rd_addr_i one cycle after the address is applied.
- R10: Capture stops at the lower of the record length and the 64-word buffer depth. On the edge that writes the final word, cap_full_o is set, done_o pulses and busy_o falls. Later samples change neither cap_level_o nor the stored words.
- R11: The accumulators do not overflow at full scale. A 4096-sample record of -32768 at tuning word 0 gives I = -32768*2047*4096 and Q = 0 exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request; configuration is latched when accepted |
| mode_i | input | 1 | 0 = detect, 1 = raw capture |
| rec_len_i | input | 13 | Record length in samples (0..4096) |
| tune_i | input | 32 | NCO phase increment per sample |
| samp_i | input | 64 | Four signed 16-bit samples |
| samp_valid_i | input | 1 | Sample strobe |
| busy_o | output | 1 | Record in progress |
| done_o | output | 1 | One-cycle completion pulse, either mode |
| res_valid_o | output | 1 | One-cycle pulse when new I/Q results are present |
| res_i_o | output | 164 | Four signed 41-bit in-phase sums |
| res_q_o | output | 164 | Four signed 41-bit quadrature sums |
| cap_full_o | output | 1 | Capture has ended |
| cap_level_o | output | 7 | Words stored by the last capture |
| cap_rd_addr_i | input | 6 | Capture buffer read address |
| cap_rd_data_o | output | 64 | Capture buffer read data, one-cycle latency |

## Verification
The embedded assertions check the handshake on every cycle:
- done_o is a single-cycle pulse.
- busy_o only falls together with done_o, and a result is never flagged while busy_o is high.
- The latched configuration stays frozen against starts that arrive mid-record.
- The NCO phase moves only on counted samples.
- The capture level never exceeds the buffer depth and stays frozen once full.
- A zero-length start completes on the next edge.

The numerical content can only be shown by the bench scenarios: whether the sums match a sinusoid of known amplitude and phase at several oversampling ratios, with gaps in the valid strobe and at full-scale input, and whether captured words come back intact.

// File: rtl/iqd_pkg.sv
package iqd_pkg;
  typedef enum logic {MODE_DETECT = 1'b0, MODE_CAPTURE = 1'b1} iqd_mode_e;

  // Rational sine approximation, integer only, for ROM elaboration.
  function automatic int sin_entry(int k, int depth, int amp);
    int     half;
    int     p;
    longint pp;
    longint num;
    longint den;
    int     v;
    half = depth / 2;
    p    = (k < half) ? k : k - half;
    pp   = longint'(p) * longint'(half - p);
    num  = longint'(amp) * 16 * pp;
    den  = 5 * longint'(half) * longint'(half) - 4 * pp;
    v    = int'((num + den / 2) / den);
    return (k < half) ? v : -v;
  endfunction
endpackage

// File: rtl/iqd_nco.sv
module iqd_nco #(
  parameter int PHW = 32,
  parameter int AW  = 8,
  parameter int TW  = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clear_i,
  input  logic                 adv_i,
  input  logic [PHW-1:0]       tune_i,
  output logic signed [TW-1:0] cos_o,
  output logic signed [TW-1:0] sin_o
);
  localparam int DEPTH = 1 << AW;
  localparam int AMP   = (1 << (TW - 1)) - 1;
  localparam int QTR   = DEPTH / 4;

  logic [PHW-1:0]       phase_q, tune_q;
  logic [AW-1:0]        idx;
  logic signed [TW-1:0] rom [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_rom
    assign rom[k] = TW'(iqd_pkg::sin_entry(k, DEPTH, AMP));
  end

  assign idx   = phase_q[PHW-1 -: AW];
  assign sin_o = rom[idx];
  assign cos_o = rom[idx + AW'(QTR)];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      tune_q  <= '0;
    end else if (clear_i) begin
      phase_q <= '0;
      tune_q  <= tune_i;
    end else if (adv_i) begin
      phase_q <= phase_q + tune_q;
    end
  end

  assert_phase_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i && !clear_i |=> $stable(phase_q));
endmodule

// File: rtl/iqd_mac.sv
module iqd_mac #(
  parameter int SW   = 16,
  parameter int TW   = 12,
  parameter int ACCW = 41
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clear_i,
  input  logic                   zero_i,
  input  logic                   en_i,
  input  logic                   last_i,
  input  logic signed [SW-1:0]   x_i,
  input  logic signed [TW-1:0]   c_i,
  input  logic signed [TW-1:0]   s_i,
  output logic signed [ACCW-1:0] res_i_o,
  output logic signed [ACCW-1:0] res_q_o
);
  localparam int PW = SW + TW;

  logic signed [PW-1:0]   prod_i, prod_q;
  logic signed [ACCW-1:0] acc_i_q, acc_q_q, sum_i, sum_q, res_i_q, res_q_q;

  assign prod_i = x_i * c_i;
  assign prod_q = x_i * s_i;
  assign sum_i  = acc_i_q + {{(ACCW-PW){prod_i[PW-1]}}, prod_i};
  assign sum_q  = acc_q_q + {{(ACCW-PW){prod_q[PW-1]}}, prod_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_i_q <= '0;
      acc_q_q <= '0;
      res_i_q <= '0;
      res_q_q <= '0;
    end else begin
      if (clear_i) begin
        acc_i_q <= '0;
        acc_q_q <= '0;
      end else if (en_i) begin
        acc_i_q <= sum_i;
        acc_q_q <= sum_q;
      end
      if (zero_i) begin
        res_i_q <= '0;
        res_q_q <= '0;
      end else if (en_i && last_i) begin
        res_i_q <= sum_i;
        res_q_q <= sum_q;
      end
    end
  end

  assign res_i_o = res_i_q;
  assign res_q_o = res_q_q;

  assert_res_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !zero_i |=> $stable(res_i_q) && $stable(res_q_q));
endmodule

// File: rtl/iqd_capture.sv
module iqd_capture #(
  parameter int WW    = 64,
  parameter int DEPTH = 64,
  parameter int LW    = 13,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic [LW-1:0] len_i,
  input  logic          we_i,
  input  logic [WW-1:0] wdata_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [WW-1:0] rd_data_o,
  output logic          full_o,
  output logic [CW-1:0] level_o,
  output logic          end_o
);
  logic [WW-1:0] mem [DEPTH];
  logic [WW-1:0] rd_q;
  logic [CW-1:0] level_q, target_q;
  logic          full_q, wr;

  assign wr    = we_i && !full_q;
  assign end_o = wr && (level_q + CW'(1) == target_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q  <= '0;
      target_q <= '0;
      full_q   <= 1'b0;
    end else if (clear_i) begin
      level_q  <= '0;
      target_q <= (len_i >= LW'(DEPTH)) ? CW'(DEPTH) : CW'(len_i);
      full_q   <= (len_i == '0);
    end else if (wr) begin
      level_q <= level_q + CW'(1);
      if (end_o) full_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr) mem[level_q[AW-1:0]] <= wdata_i;
    rd_q <= mem[rd_addr_i];
  end

  assign rd_data_o = rd_q;
  assign full_o    = full_q;
  assign level_o   = level_q;

  assert_level_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= CW'(DEPTH));
  assert_full_freeze_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q && !clear_i |=> $stable(level_q));
endmodule

// File: rtl/iq_detector.sv
module iq_detector
  import iqd_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int SW        = 16,
  parameter int TW        = 12,
  parameter int PHW       = 32,
  parameter int LUT_AW    = 8,
  parameter int MAX_LEN   = 4096,
  parameter int CAP_DEPTH = 64,
  localparam int LENW     = $clog2(MAX_LEN + 1),
  localparam int ACCW     = SW + TW + LENW,
  localparam int CAW      = $clog2(CAP_DEPTH),
  localparam int WW       = NCH * SW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic [LENW-1:0]   rec_len_i,
  input  logic [PHW-1:0]    tune_i,
  input  logic [WW-1:0]     samp_i,
  input  logic              samp_valid_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              res_valid_o,
  output logic [NCH*ACCW-1:0] res_i_o,
  output logic [NCH*ACCW-1:0] res_q_o,
  output logic              cap_full_o,
  output logic [CAW:0]      cap_level_o,
  input  logic [CAW-1:0]    cap_rd_addr_i,
  output logic [WW-1:0]     cap_rd_data_o
);
  iqd_mode_e            mode_q;
  logic                 busy_q, done_q, rv_q;
  logic [LENW-1:0]      len_q, take_q;
  logic                 start_ok, det_acc, take_last, cap_we, cap_end;
  logic                 s1_v, s1_last;
  logic [WW-1:0]        samp_q;
  logic signed [TW-1:0] nco_cos, nco_sin, cos_q, sin_q;
  logic                 zero_det;

  assign start_ok  = start_i && !busy_q;
  assign det_acc   = busy_q && (mode_q == MODE_DETECT) && samp_valid_i && (take_q != len_q);
  assign take_last = det_acc && (take_q == len_q - LENW'(1));
  assign cap_we    = busy_q && (mode_q == MODE_CAPTURE) && samp_valid_i;
  assign zero_det  = start_ok && (rec_len_i == '0) && (mode_i == MODE_DETECT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_DETECT;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      rv_q    <= 1'b0;
      len_q   <= '0;
      take_q  <= '0;
      s1_v    <= 1'b0;
      s1_last <= 1'b0;
      samp_q  <= '0;
      cos_q   <= '0;
      sin_q   <= '0;
    end else begin
      done_q  <= 1'b0;
      rv_q    <= 1'b0;
      s1_v    <= det_acc;
      s1_last <= take_last;
      if (det_acc) begin
        samp_q <= samp_i;
        cos_q  <= nco_cos;
        sin_q  <= nco_sin;
        take_q <= take_q + LENW'(1);
      end
      if (start_ok) begin
        mode_q <= iqd_mode_e'(mode_i);
        len_q  <= rec_len_i;
        take_q <= '0;
        if (rec_len_i == '0) begin
          done_q <= 1'b1;
          rv_q   <= (mode_i == MODE_DETECT);
        end else begin
          busy_q <= 1'b1;
        end
      end else if (busy_q && ((s1_v && s1_last) || cap_end)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        rv_q   <= (mode_q == MODE_DETECT);
      end
    end
  end

  iqd_nco #(.PHW(PHW), .AW(LUT_AW), .TW(TW)) u_nco (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (start_ok),
    .adv_i   (det_acc),
    .tune_i  (tune_i),
    .cos_o   (nco_cos),
    .sin_o   (nco_sin)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    iqd_mac #(.SW(SW), .TW(TW), .ACCW(ACCW)) u_mac (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (start_ok),
      .zero_i  (zero_det),
      .en_i    (s1_v),
      .last_i  (s1_last),
      .x_i     (samp_q[c*SW +: SW]),
      .c_i     (cos_q),
      .s_i     (sin_q),
      .res_i_o (res_i_o[c*ACCW +: ACCW]),
      .res_q_o (res_q_o[c*ACCW +: ACCW])
    );
  end

  iqd_capture #(.WW(WW), .DEPTH(CAP_DEPTH), .LW(LENW)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (start_ok && (mode_i == MODE_CAPTURE)),
    .len_i     (rec_len_i),
    .we_i      (cap_we),
    .wdata_i   (samp_i),
    .rd_addr_i (cap_rd_addr_i),
    .rd_data_o (cap_rd_data_o),
    .full_o    (cap_full_o),
    .level_o   (cap_level_o),
    .end_o     (cap_end)
  );

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign res_valid_o = rv_q;

  assert_done_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_busy_end_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> done_q);
  assert_result_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rv_q |-> !busy_q);
  assert_cfg_locked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && start_i |=> (len_q == $past(len_q)) && (mode_q == $past(mode_q)));
  assert_zero_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_q && (rec_len_i == '0) |=> done_q && !busy_q);
  assert_take_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_q <= len_q);
endmodule

// File: tb/iq_detector_tb.sv
`timescale 1ns/1ps
module iq_detector_tb;
  localparam int NCH  = 4;
  localparam int SW   = 16;
  localparam int LENW = 13;
  localparam int ACCW = 41;
  localparam int CAW  = 6;
  localparam int WW   = NCH * SW;
  localparam real PI  = 3.14159265358979;

  typedef struct packed {
    logic [NCH-1:0][63:0] ei;
    logic [NCH-1:0][63:0] eq;
    logic [NCH-1:0][63:0] tol;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic start_i = 0, mode_i = 0, samp_valid_i = 0;
  logic [LENW-1:0] rec_len_i = '0;
  logic [31:0] tune_i = '0;
  logic [WW-1:0] samp_i = '0;
  logic [CAW-1:0] cap_rd_addr_i = '0;
  logic busy_o, done_o, res_valid_o, cap_full_o;
  logic [NCH*ACCW-1:0] res_i_o, res_q_o;
  logic [CAW:0] cap_level_o;
  logic [WW-1:0] cap_rd_data_o;

  int nchk = 0, nfail = 0;
  exp_t expq[$];
  string tagq[$];
  longint last_i0 = 0;
  real amp_v[NCH];
  real phi_v[NCH];

  always #2.5 clk = ~clk;

  iq_detector u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .mode_i(mode_i),
    .rec_len_i(rec_len_i), .tune_i(tune_i), .samp_i(samp_i),
    .samp_valid_i(samp_valid_i), .busy_o(busy_o), .done_o(done_o),
    .res_valid_o(res_valid_o), .res_i_o(res_i_o), .res_q_o(res_q_o),
    .cap_full_o(cap_full_o), .cap_level_o(cap_level_o),
    .cap_rd_addr_i(cap_rd_addr_i), .cap_rd_data_o(cap_rd_data_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] cap_word(input int n);
    logic [WW-1:0] w;
    for (int c = 0; c < NCH; c++) w[c*SW +: SW] = SW'(n * 37 + c * 1000 - 500);
    return w;
  endfunction

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && res_valid_o) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R4 unexpected res_valid", 1, 0);
      end else begin
        exp_t e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        for (int c = 0; c < NCH; c++) begin
          longint ai, aq, di, dq;
          ai = longint'($signed(res_i_o[c*ACCW +: ACCW]));
          aq = longint'($signed(res_q_o[c*ACCW +: ACCW]));
          di = ai - $signed(e.ei[c]);
          dq = aq - $signed(e.eq[c]);
          if (di < 0) di = -di;
          if (dq < 0) dq = -dq;
          chk(di <= $signed(e.tol[c]), {t, " I"}, ai, $signed(e.ei[c]));
          chk(dq <= $signed(e.tol[c]), {t, " Q"}, aq, $signed(e.eq[c]));
          if (c == 0) last_i0 = ai;
        end
      end
    end
  end

  task automatic start_cmd(input logic m, input int len, input logic [31:0] tw);
    @(negedge clk);
    mode_i = m; rec_len_i = LENW'(len); tune_i = tw; start_i = 1;
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic run_record(input logic [31:0] tw, input int len, input bit gap,
                            input bit dbl, input bit timing, input bit fixed,
                            input string tag);
    exp_t e;
    real si[NCH], sq[NCH];
    longint tl[NCH];
    logic [31:0] ph;
    real w;
    for (int c = 0; c < NCH; c++) begin si[c] = 0.0; sq[c] = 0.0; tl[c] = 2; end
    w  = 2.0 * PI * real'(tw) / 4294967296.0;
    ph = '0;
    start_cmd(1'b0, len, tw);
    chk(busy_o == 1'b1, "R4 busy after start", longint'(busy_o), 1);
    for (int n = 0; n < len; n++) begin
      int k;
      real lc, ls;
      logic [WW-1:0] word;
      if (gap && (n % 3 == 1)) begin
        @(negedge clk);
        samp_valid_i = 0; start_i = 0;
      end
      k  = int'(ph[31:24]);
      lc = 2047.0 * $cos(2.0 * PI * k / 256.0);
      ls = 2047.0 * $sin(2.0 * PI * k / 256.0);
      for (int c = 0; c < NCH; c++) begin
        int x;
        x = fixed ? -32768 : int'(amp_v[c] * $cos(w * n + phi_v[c]));
        word[c*SW +: SW] = SW'(x);
        si[c] += real'(x) * lc;
        sq[c] += real'(x) * ls;
        if (k % 64 != 0) tl[c] += 4 * ((x < 0) ? -x : x);
      end
      @(negedge clk);
      samp_i = word; samp_valid_i = 1;
      start_i = dbl && (n == len / 2);
      if (start_i) begin rec_len_i = LENW'(5); mode_i = 1'b1; end
      ph += tw;
    end
    for (int c = 0; c < NCH; c++) begin
      e.ei[c]  = longint'(si[c]);
      e.eq[c]  = longint'(sq[c]);
      e.tol[c] = tl[c];
    end
    expq.push_back(e);
    tagq.push_back(tag);
    @(negedge clk);
    samp_valid_i = 0; start_i = 0;
    if (timing) begin
      chk(busy_o && !res_valid_o, "R4 still busy one cycle after last sample", longint'(res_valid_o), 0);
      @(negedge clk);
      chk(res_valid_o && done_o && !busy_o, "R4 result two cycles after last sample", longint'(res_valid_o), 1);
      @(negedge clk);
      chk(!res_valid_o && !done_o, "R4 result pulse one cycle", longint'(res_valid_o), 0);
    end else begin
      while (busy_o) @(negedge clk);
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin : main
    exp_t z;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(!busy_o && !done_o && !res_valid_o && !cap_full_o, "R1 flags after reset", 0, 0);
    chk(res_i_o == '0 && res_q_o == '0 && cap_level_o == '0, "R1 results after reset", 0, 0);

    // R2 R3: IF at fs/10, distinct amplitude and phase per channel
    amp_v[0] = 8000.0;  phi_v[0] = 0.0;
    amp_v[1] = 12000.0; phi_v[1] = 1.0472;
    amp_v[2] = 3000.0;  phi_v[2] = -1.5708;
    amp_v[3] = 20000.0; phi_v[3] = 2.0;
    run_record(32'd429496730, 1000, 1'b0, 1'b0, 1'b1, 1'b0, "R2_R3 fs/10");

    // R8: hold, idle samples ignored
    repeat (3) begin
      @(negedge clk); samp_i = cap_word(7); samp_valid_i = 1;
    end
    @(negedge clk); samp_valid_i = 0;
    chk(longint'($signed(res_i_o[ACCW-1:0])) == last_i0, "R8 result held",
        longint'($signed(res_i_o[ACCW-1:0])), last_i0);
    chk(!busy_o && !res_valid_o, "R8 idle samples start nothing", longint'(busy_o), 0);

    // R5 R6: 4x oversampling with valid gaps and a start mid-record
    run_record(32'h4000_0000, 600, 1'b1, 1'b1, 1'b0, 1'b0, "R5_R6 fs/4 gaps");
    chk(cap_level_o == '0 && !cap_full_o, "R6 ignored start left capture untouched",
        longint'(cap_level_o), 0);

    // R2: 100x oversampling
    run_record(32'd42949673, 1000, 1'b0, 1'b0, 1'b1, 1'b0, "R2 fs/100");

    // R11: full scale over maximum length
    run_record(32'd0, 4096, 1'b0, 1'b0, 1'b0, 1'b1, "R11 full scale");

    // R7 detect, zero length
    for (int c = 0; c < NCH; c++) begin z.ei[c] = '0; z.eq[c] = '0; z.tol[c] = '0; end
    expq.push_back(z); tagq.push_back("R7 zero length");
    start_cmd(1'b0, 0, 32'd123);
    chk(done_o && res_valid_o && !busy_o, "R7 immediate done", longint'(done_o), 1);

    // R9 R10: capture 20 words
    start_cmd(1'b1, 20, 32'd0);
    chk(busy_o == 1'b1, "R9 busy in capture", longint'(busy_o), 1);
    for (int n = 0; n < 20; n++) begin
      @(negedge clk); samp_i = cap_word(n); samp_valid_i = 1;
    end
    @(negedge clk); samp_valid_i = 0;
    chk(done_o && cap_full_o && !busy_o, "R10 capture end flags", longint'(cap_full_o), 1);
    chk(cap_level_o == 7'd20, "R10 capture level", longint'(cap_level_o), 20);
    for (int n = 0; n < 5; n++) begin
      @(negedge clk); samp_i = cap_word(900 + n); samp_valid_i = 1;
    end
    @(negedge clk); samp_valid_i = 0;
    chk(cap_level_o == 7'd20, "R10 extra samples ignored", longint'(cap_level_o), 20);
    for (int a = 0; a < 20; a++) begin
      @(negedge clk); cap_rd_addr_i = CAW'(a);
      @(negedge clk);
      chk(cap_rd_data_o == cap_word(a), "R9 readback", longint'(cap_rd_data_o[31:0]),
          longint'(cap_word(a)[31:0]));
    end

    // R10: request beyond depth stops at 64
    start_cmd(1'b1, 100, 32'd0);
    for (int n = 0; n < 70; n++) begin
      @(negedge clk); samp_i = cap_word(200 + n); samp_valid_i = 1;
    end
    @(negedge clk); samp_valid_i = 0;
    chk(cap_full_o && !busy_o && cap_level_o == 7'd64, "R10 depth limit",
        longint'(cap_level_o), 64);
    @(negedge clk); cap_rd_addr_i = CAW'(63);
    @(negedge clk);
    chk(cap_rd_data_o == cap_word(263), "R10 last word kept",
        longint'(cap_rd_data_o[31:0]), longint'(cap_word(263)[31:0]));
    @(negedge clk); cap_rd_addr_i = CAW'(0);
    @(negedge clk);
    chk(cap_rd_data_o == cap_word(200), "R9 first word",
        longint'(cap_rd_data_o[31:0]), longint'(cap_word(200)[31:0]));

    // R7 capture, zero length
    start_cmd(1'b1, 0, 32'd0);
    chk(done_o && cap_full_o && !busy_o && !res_valid_o && cap_level_o == '0,
        "R7 capture zero length", longint'(cap_level_o), 0);

    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R4 all results delivered", longint'(expq.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule